// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Interrupts

This block is a memory-mapped general-purpose I/O controller. Pins are grouped into register sets of 32, and each set has its own window on a simple register bus. Within a set, software picks each pin's direction and drives outputs through separate write-one-to-set and write-one-to-clear registers, so one pin can change without a read-modify-write. Software enables rising-edge and falling-edge detection per pin the same way. The live pin levels can be read through a synchronizer.

An enabled edge latches a bit in the set's interrupt status register, and software clears that bit by writing a one to it. The status bits are grouped into 16-pin interrupt banks: the low half of set k feeds bank 2k and the high half feeds bank 2k+1. Each bank output is a level signal, gated by one bit of a global bank-enable register. The pin count can be set from 1 to 144, and the last set may be only partly filled.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After reset every pin is an input with its output enable low, output data is zero, all edge enables and status bits are zero, all bank enables are zero, and every bank interrupt is low.
- R2: Set register offset 0x00 holds direction, one bit per pin. A bit of 1 makes the pin an input and 0 drives `pin_oe` high for it. A write takes effect on the clock edge that samples it, and a read returns the stored value.
- R3: Writing a mask to set offset 0x08 drives the masked output bits high, and writing a mask to set offset 0x0C drives them low. Zero bits leave the outputs unchanged. Offset 0x04 reads back the output register and a write there loads it directly. `pin_out` follows the register.
- R4: Set offset 0x10 returns the pin levels after a two-flop synchronizer, including pins that are driven as outputs. A level applied just before a read is not yet visible, and it is visible two idle cycles later.
- R5: The rising-edge enables are set by writing ones to set offset 0x14 and cleared by writing ones to 0x18. The falling-edge enables use 0x1C (set) and 0x20 (clear). Reading either address of a pair returns the current enable mask.
- R6: An edge on a pin sets its status bit (set offset 0x24) only if that edge direction is enabled. A pin with both directions enabled latches on either edge. Edges in a disabled direction are ignored.
- R7: Writing ones to set offset 0x24 clears those status bits, and zero bits are kept. If a new enabled edge arrives in the same cycle as the clear, the bit stays set.
- R8: `bank_irq[2k]` is the OR of status bits 0..15 of set k, and `bank_irq[2k+1]` is the OR of bits 16..31. Each is ANDed with bit b of the bank-enable register at byte address 0x08. Clearing the enable drops the output while the status is kept.
- R9: Set k occupies byte addresses 0x10 + 0x28·k through 0x10 + 0x28·k + 0x24, so the set bases are 0x10, 0x38, 0x60, 0x88 and 0xB0.
- R10: In a partly filled last set, the bits for pins at or above `NUM_PINS` always read as zero from direction, output, enable and status, and they never latch an edge.
- R11: A read request is answered on `bus_rdata` with `bus_rvalid` high in the following cycle. Unmapped or non-word-aligned addresses read zero, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access request for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| bus_rvalid | output | 1 | Read data valid, one cycle after the request |
| pin_in | input | NUM_PINS | Pin levels from the pads |
| pin_out | output | NUM_PINS | Output data to the pads |
| pin_oe | output | NUM_PINS | Output enable per pin (1 = drive) |
| bank_irq | output | ceil(NUM_PINS/16) | Level interrupt per 16-pin bank |

## Verification
The bound checker checks on every cycle that no bank interrupt is high while its bank enable is clear. It also checks that `pin_oe` and `pin_out` change only in the cycle after a bus write, and that `bus_rvalid` follows read requests exactly one cycle later. The bench scenarios cover the rest:
- edges in enabled and disabled directions, and pins with both directions enabled;
- a clear that lands in the same cycle as a new edge;
- the synchronizer lag on the input view;
- the mapping of status halves to bank outputs across two sets;
- the masking of unpopulated pins in a partly filled set;
- reads of unmapped and unaligned addresses.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

   localparam int PINS_PER_SET  = 32;
   localparam int PINS_PER_BANK = 16;
   localparam int MAX_PINS      = 144;

   localparam logic [7:0] BANK_EN_ADDR = 8'h08;
   localparam logic [7:0] SET0_BASE    = 8'h10;
   localparam logic [7:0] SET_STRIDE   = 8'h28;
   localparam logic [7:0] SET_LAST_REG = 8'h24;

   // word index of a register inside one set window
   typedef enum logic [3:0] {
      RG_DIR      = 4'd0,
      RG_OUT      = 4'd1,
      RG_OUT_SET  = 4'd2,
      RG_OUT_CLR  = 4'd3,
      RG_IN       = 4'd4,
      RG_RISE_SET = 4'd5,
      RG_RISE_CLR = 4'd6,
      RG_FALL_SET = 4'd7,
      RG_FALL_CLR = 4'd8,
      RG_STAT     = 4'd9
   } gpio_reg_e;

   function automatic logic [7:0] set_base(input int idx);
      return 8'(int'(SET0_BASE) + idx * int'(SET_STRIDE));
   endfunction

endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
   parameter int WIDTH  = 32,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o,
   output logic [WIDTH-1:0] prev_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_pin_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] chain [STAGES];
   logic [WIDTH-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) chain[i] <= '0;
         prev_q <= '0;
      end else begin
         chain[0] <= d_i;
         for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
         prev_q <= chain[STAGES-1];
      end
   end

   assign q_o    = chain[STAGES-1];
   assign prev_o = prev_q;

endmodule

// File: rtl/gpio_reg_set.sv
module gpio_reg_set
   import gpio_bank_pkg::*;
#(
   parameter int PIN_COUNT   = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [3:0]           reg_idx,
   input  logic [31:0]          wdata,
   output logic [31:0]          rdata_o,
   input  logic [PIN_COUNT-1:0] pin_i,
   output logic [PIN_COUNT-1:0] pin_o,
   output logic [PIN_COUNT-1:0] pin_oe_o,
   output logic [PIN_COUNT-1:0] stat_o
);

   if (PIN_COUNT < 1 || PIN_COUNT > PINS_PER_SET) begin : g_bad_count
      $error("gpio_reg_set: PIN_COUNT out of range");
   end

   localparam logic [31:0] LIVE = (PIN_COUNT >= PINS_PER_SET) ? 32'hFFFF_FFFF
                                  : 32'((64'd1 << PIN_COUNT) - 64'd1);

   logic [31:0] pin_w;
   if (PIN_COUNT == PINS_PER_SET) begin : g_full
      assign pin_w = pin_i;
   end else begin : g_part
      assign pin_w = {{(PINS_PER_SET-PIN_COUNT){1'b0}}, pin_i};
   end

   logic [31:0] sync_w, prev_w;
   gpio_pin_sync #(.WIDTH(PINS_PER_SET), .STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .d_i    (pin_w),
      .q_o    (sync_w),
      .prev_o (prev_w)
   );

   logic [31:0] dir_q, out_q, rise_q, fall_q, stat_q;
   logic [31:0] wmask, edge_hit, stat_clr;
   gpio_reg_e   rsel;

   assign rsel     = gpio_reg_e'(reg_idx);
   assign wmask    = wdata & LIVE;
   assign edge_hit = ((sync_w & ~prev_w & rise_q) | (~sync_w & prev_w & fall_q)) & LIVE;
   assign stat_clr = (wr_en && rsel == RG_STAT) ? wdata : 32'h0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q  <= 32'hFFFF_FFFF;
         out_q  <= '0;
         rise_q <= '0;
         fall_q <= '0;
      end else if (wr_en) begin
         case (rsel)
            RG_DIR:      dir_q  <= wdata | ~LIVE;
            RG_OUT:      out_q  <= wmask;
            RG_OUT_SET:  out_q  <= out_q | wmask;
            RG_OUT_CLR:  out_q  <= out_q & ~wmask;
            RG_RISE_SET: rise_q <= rise_q | wmask;
            RG_RISE_CLR: rise_q <= rise_q & ~wmask;
            RG_FALL_SET: fall_q <= fall_q | wmask;
            RG_FALL_CLR: fall_q <= fall_q & ~wmask;
            default: ;
         endcase
      end
   end

   // a fresh edge wins over a same-cycle clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stat_q <= '0;
      else        stat_q <= ((stat_q & ~stat_clr) | edge_hit) & LIVE;
   end

   always_comb begin
      case (rsel)
         RG_DIR:                              rdata_o = dir_q & LIVE;
         RG_OUT, RG_OUT_SET, RG_OUT_CLR:      rdata_o = out_q;
         RG_IN:                               rdata_o = sync_w;
         RG_RISE_SET, RG_RISE_CLR:            rdata_o = rise_q;
         RG_FALL_SET, RG_FALL_CLR:            rdata_o = fall_q;
         RG_STAT:                             rdata_o = stat_q;
         default:                             rdata_o = 32'h0;
      endcase
   end

   assign pin_o    = out_q[PIN_COUNT-1:0];
   assign pin_oe_o = ~dir_q[PIN_COUNT-1:0];
   assign stat_o   = stat_q[PIN_COUNT-1:0];

endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
   import gpio_bank_pkg::*;
#(
   parameter  int NUM_PINS    = 144,
   parameter  int SYNC_STAGES = 2,
   localparam int NBANK       = (NUM_PINS + PINS_PER_BANK - 1) / PINS_PER_BANK
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bus_sel,
   input  logic                bus_wr,
   input  logic [7:0]          bus_addr,
   input  logic [31:0]         bus_wdata,
   output logic [31:0]         bus_rdata,
   output logic                bus_rvalid,
   input  logic [NUM_PINS-1:0] pin_in,
   output logic [NUM_PINS-1:0] pin_out,
   output logic [NUM_PINS-1:0] pin_oe,
   output logic [NBANK-1:0]    bank_irq
);

   localparam int NSET   = (NUM_PINS + PINS_PER_SET - 1) / PINS_PER_SET;
   localparam int STAT_W = NBANK * PINS_PER_BANK;

   if (NUM_PINS < 1 || NUM_PINS > MAX_PINS) begin : g_bad_pins
      $error("gpio_bank_ctrl: NUM_PINS must be 1..144");
   end

   logic [31:0]       set_rd  [NSET];
   logic [NSET-1:0]   set_hit;
   logic [STAT_W-1:0] stat_all;
   logic [NBANK-1:0]  bank_en_q;
   logic              en_hit;

   for (genvar k = 0; k < NSET; k++) begin : g_set
      localparam int          VN   = (NUM_PINS - PINS_PER_SET*k > PINS_PER_SET)
                                     ? PINS_PER_SET : NUM_PINS - PINS_PER_SET*k;
      localparam logic [7:0]  BASE = set_base(k);

      logic [7:0] off;
      assign off        = bus_addr - BASE;
      assign set_hit[k] = (bus_addr >= BASE) && (off <= SET_LAST_REG) && (off[1:0] == 2'b00);

      gpio_reg_set #(.PIN_COUNT(VN), .SYNC_STAGES(SYNC_STAGES)) u_set (
         .clk      (clk),
         .rst_n    (rst_n),
         .wr_en    (bus_sel && bus_wr && set_hit[k]),
         .reg_idx  (off[5:2]),
         .wdata    (bus_wdata),
         .rdata_o  (set_rd[k]),
         .pin_i    (pin_in [PINS_PER_SET*k +: VN]),
         .pin_o    (pin_out[PINS_PER_SET*k +: VN]),
         .pin_oe_o (pin_oe [PINS_PER_SET*k +: VN]),
         .stat_o   (stat_all[PINS_PER_SET*k +: VN])
      );
   end

   if (STAT_W > NUM_PINS) begin : g_stat_pad
      assign stat_all[STAT_W-1:NUM_PINS] = '0;
   end

   assign en_hit = (bus_addr == BANK_EN_ADDR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          bank_en_q <= '0;
      else if (bus_sel && bus_wr && en_hit) bank_en_q <= bus_wdata[NBANK-1:0];
   end

   for (genvar b = 0; b < NBANK; b++) begin : g_bank
      assign bank_irq[b] = bank_en_q[b] & (|stat_all[PINS_PER_BANK*b +: PINS_PER_BANK]);
   end

   logic [31:0] rd_mux;
   always_comb begin
      rd_mux = 32'h0;
      if (en_hit) rd_mux = 32'(bank_en_q);
      for (int k = 0; k < NSET; k++)
         if (set_hit[k]) rd_mux = set_rd[k];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_rvalid <= 1'b0;
         bus_rdata  <= '0;
      end else begin
         bus_rvalid <= bus_sel && !bus_wr;
         if (bus_sel && !bus_wr) bus_rdata <= rd_mux;
      end
   end

endmodule

// File: rtl/gpio_bank_ctrl_chk.sv
module gpio_bank_ctrl_chk #(
   parameter int NUM_PINS = 144,
   parameter int NBANK    = 9
) (
   input logic                clk,
   input logic                rst_n,
   input logic                bus_sel,
   input logic                bus_wr,
   input logic                bus_rvalid,
   input logic [NUM_PINS-1:0] pin_out,
   input logic [NUM_PINS-1:0] pin_oe,
   input logic [NBANK-1:0]    bank_irq,
   input logic [NBANK-1:0]    bank_en
);

   AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      (bank_irq & ~bank_en) == '0);                                    // R8

   AST_OE_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(pin_oe) |-> $past(bus_sel && bus_wr));                  // R2

   AST_OUT_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(pin_out) |-> $past(bus_sel && bus_wr));                 // R3

   AST_READ_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && !bus_wr) |=> bus_rvalid);                            // R11

   AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_sel && !bus_wr) |=> !bus_rvalid);                          // R11

endmodule

bind gpio_bank_ctrl gpio_bank_ctrl_chk #(.NUM_PINS(NUM_PINS), .NBANK(NBANK)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_sel    (bus_sel),
   .bus_wr     (bus_wr),
   .bus_rvalid (bus_rvalid),
   .pin_out    (pin_out),
   .pin_oe     (pin_oe),
   .bank_irq   (bank_irq),
   .bank_en    (bank_en_q)
);

// File: tb/gpio_bank_ctrl_test.sv
module gpio_bank_ctrl_test;

   localparam int NP = 48;
   localparam int NB = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_sel = 1'b0;
   logic          bus_wr = 1'b0;
   logic [7:0]    bus_addr = '0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic          bus_rvalid;
   logic [NP-1:0] pin_in = '0;
   logic [NP-1:0] pin_out, pin_oe;
   logic [NB-1:0] bank_irq;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   typedef struct {
      logic [7:0]  addr;
      logic [31:0] exp;
      string       tag;
   } rd_item_t;
   rd_item_t exp_q [$];

   always #2 clk = ~clk;

   gpio_bank_ctrl #(.NUM_PINS(NP)) uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_sel    (bus_sel),
      .bus_wr     (bus_wr),
      .bus_addr   (bus_addr),
      .bus_wdata  (bus_wdata),
      .bus_rdata  (bus_rdata),
      .bus_rvalid (bus_rvalid),
      .pin_in     (pin_in),
      .pin_out    (pin_out),
      .pin_oe     (pin_oe),
      .bank_irq   (bank_irq)
   );

   task automatic check_eq(input logic [63:0] act, input logic [63:0] exp, input string tag);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk); @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [7:0] a, input logic [31:0] exp, input string tag);
      rd_item_t it;
      it.addr = a; it.exp = exp; it.tag = tag;
      exp_q.push_back(it);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      @(posedge clk); @(negedge clk);
      bus_sel = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   // monitor: pops expected read results as the design answers
   always @(posedge clk) begin
      #1;
      if (bus_rvalid) begin
         if (exp_q.size() == 0) begin
            checks++; errors++;
            $display("FAIL R11 unexpected read data actual=%h expected=none", bus_rdata);
         end else begin
            rd_item_t it;
            it = exp_q.pop_front();
            check_eq(64'(bus_rdata), 64'(it.exp), it.tag);
         end
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      idle(1);

      // R1 reset state
      check_eq(64'(pin_oe), 64'h0, "R1 pin_oe after reset");
      check_eq(64'(pin_out), 64'h0, "R1 pin_out after reset");
      check_eq(64'(bank_irq), 64'h0, "R1 bank_irq after reset");
      bus_read(8'h10, 32'hFFFF_FFFF, "R1 set0 dir reset");
      bus_read(8'h38, 32'h0000_FFFF, "R10 set1 dir reset masked");
      bus_read(8'h34, 32'h0, "R1 set0 status reset");
      bus_read(8'h24, 32'h0, "R1 set0 rise enable reset");
      bus_read(8'h08, 32'h0, "R1 bank enable reset");

      // R2 direction
      bus_write(8'h10, 32'hFFFF_00FF);
      bus_write(8'h38, 32'h0);
      check_eq(64'(pin_oe), 64'hFFFF_0000_FF00, "R2 pin_oe from dir");
      bus_read(8'h10, 32'hFFFF_00FF, "R2 set0 dir readback");
      bus_read(8'h38, 32'h0, "R2 set1 dir readback");

      // R3 atomic set/clear of outputs
      bus_write(8'h18, 32'h0000_0F0F);
      bus_write(8'h1C, 32'h0000_0101);
      check_eq(64'(pin_out), 64'h0E0E, "R3 pin_out after set/clr");
      bus_read(8'h14, 32'h0000_0E0E, "R3 out_data readback");
      bus_write(8'h14, 32'h8000_0000);
      check_eq(64'(pin_out), 64'h8000_0000, "R3 pin_out after direct load");

      // R4 synchronized input view, including output pins
      pin_in = {16'h003C, 32'hA5A5_0100};
      bus_read(8'h20, 32'h0, "R4 input not yet visible");
      idle(2);
      bus_read(8'h20, 32'hA5A5_0100, "R4 input visible after sync");
      bus_read(8'h48, 32'h0000_003C, "R9 set1 input view");
      pin_in = '0;
      idle(4);

      // R5 edge enables
      bus_write(8'h24, 32'h5);
      bus_write(8'h2C, 32'h6);
      bus_read(8'h24, 32'h5, "R5 rise enable via set addr");
      bus_read(8'h28, 32'h5, "R5 rise enable via clr addr");
      bus_read(8'h30, 32'h6, "R5 fall enable via clr addr");

      // R6 edge detection
      pin_in[3:0] = 4'hF;
      idle(4);
      bus_read(8'h34, 32'h5, "R6 rising edges latched");
      check_eq(64'(bank_irq), 64'h0, "R8 irq gated by disabled bank");
      pin_in[3:0] = 4'h0;
      idle(4);
      bus_read(8'h34, 32'h7, "R6 falling edges latched, both-edge pin");

      // R8 bank enable
      bus_write(8'h08, 32'h1);
      check_eq(64'(bank_irq), 64'h1, "R8 bank0 enabled");
      bus_write(8'h08, 32'h7);
      check_eq(64'(bank_irq), 64'h1, "R8 only bank0 pending");
      bus_read(8'h08, 32'h7, "R8 bank enable readback");

      // R7 write-one-to-clear
      bus_write(8'h34, 32'h1);
      bus_read(8'h34, 32'h6, "R7 partial clear");
      check_eq(64'(bank_irq), 64'h1, "R7 irq still pending");
      bus_write(8'h34, 32'h6);
      check_eq(64'(bank_irq), 64'h0, "R7 irq drops after clear");

      // R7 clear colliding with a fresh edge
      bus_write(8'h24, 32'h10);
      pin_in[4] = 1'b1;
      @(posedge clk); @(posedge clk); @(negedge clk);
      bus_write(8'h34, 32'h10);
      bus_read(8'h34, 32'h10, "R7 edge wins over same-cycle clear");
      check_eq(64'(bank_irq), 64'h1, "R7 irq after collision");
      bus_write(8'h34, 32'h10);
      bus_read(8'h34, 32'h0, "R7 clear after collision");

      // R8 high half of set0 feeds bank1
      bus_write(8'h24, 32'h0010_0000);
      pin_in[20] = 1'b1;
      idle(4);
      check_eq(64'(bank_irq), 64'h2, "R8 high half drives bank1");
      bus_read(8'h34, 32'h0010_0000, "R8 status bit 20");
      bus_write(8'h34, 32'h0010_0000);

      // R9 / R10 second set, partly filled
      bus_write(8'h4C, 32'hFFFF_FFFF);
      bus_read(8'h4C, 32'h0000_FFFF, "R10 unpopulated enables read zero");
      pin_in[32] = 1'b1;
      idle(4);
      bus_read(8'h5C, 32'h1, "R9 set1 status at base 0x38");
      check_eq(64'(bank_irq), 64'h4, "R9 set1 low half drives bank2");
      bus_write(8'h08, 32'h3);
      check_eq(64'(bank_irq), 64'h0, "R8 disabling bank2 drops irq");
      bus_read(8'h5C, 32'h1, "R8 status kept while bank disabled");

      // R6 disabled direction ignored
      bus_write(8'h28, 32'h1);
      pin_in[0] = 1'b1;
      idle(4);
      bus_read(8'h34, 32'h0, "R6 edge ignored after enable cleared");

      // R11 unmapped and unaligned
      bus_read(8'h00, 32'h0, "R11 unmapped 0x00");
      bus_read(8'h0C, 32'h0, "R11 unmapped 0x0C");
      bus_read(8'h60, 32'h0, "R11 absent set2");
      bus_read(8'h11, 32'h0, "R11 unaligned");
      bus_write(8'h11, 32'h0);
      bus_read(8'h10, 32'hFFFF_00FF, "R11 unaligned write ignored");

      idle(3);
      check_eq(64'(exp_q.size()), 64'h0, "R11 every read answered");
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog run did not finish actual=hung expected=done");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule